// File: doc/BRIEF.md
# Set-Dueling Insertion Policy Selector

This block decides, for every line fill into an LRU-ordered cache, whether the incoming line enters its set at the most-recently-used end of the recency stack or at the least-recently-used end. It lets two insertion policies compete at run time. The first is the classic one, where every fill goes to MRU. The second is bimodal, where a fill goes to LRU except for a rare pseudo-random one that goes to MRU. A small group of leader sets is pinned to each policy. Misses in those leader sets move one saturating selector counter, and the counter's top bit tells every other (follower) set which policy to use.

The cache controller presents each miss (set index plus strobe) and each fill (set index plus strobe) in the cycle they happen. The block returns the insert-at-MRU decision for that fill combinationally, in the same cycle. The recency stacks themselves live outside the block. A 16-bit LFSR inside the block supplies the bimodal throttle and steps once per fill.

With default parameters the set index is 10 bits, the counter is 10 bits and the throttle is 1/32.

Top module: `set_duel_insert`

## Requirements
- R1: After reset the selector counter holds 511 (its lower middle value), `follow_bip` is 0, and the LFSR state is 16'hACE1.
- R2: A set index is an MRU-leader when bits [9:5] equal bits [4:0]. It is a bimodal-leader when bits [9:5] equal the bitwise inverse of bits [4:0]. Every other index is a follower.
- R3: A miss in an MRU-leader set raises the counter by one at the next clock edge, except when the counter already holds 1023, where it stays.
- R4: A miss in a bimodal-leader set lowers the counter by one at the next clock edge, except when the counter already holds 0, where it stays.
- R5: A miss in a follower set leaves the counter unchanged. So does a cycle without `miss_vld`.
- R6: `follow_bip` equals the counter's top bit (bit 9), which means it is 1 when the counter is 512 or above.
- R7: A fill into an MRU-leader set always gives `ins_mru` = 1.
- R8: A fill into a bimodal-leader set gives `ins_mru` = 1 exactly when the low 5 bits of the current LFSR state are all zero.
- R9: A fill into a follower set gives `ins_mru` = 1 when `follow_bip` is 0. When `follow_bip` is 1, it follows the bimodal draw of R8.
- R10: The LFSR steps once at each clock edge where `fill_vld` is 1, to (state >> 1) XOR (16'hB400 if state bit 0 was 1, otherwise 0). It holds its state otherwise. The fill decision always uses the state from before the step.
- R11: `ins_mru` is 0 whenever `fill_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | A miss occurred this cycle |
| miss_idx | input | 10 | Set index of the miss |
| fill_vld | input | 1 | A line fill occurs this cycle |
| fill_idx | input | 10 | Set index of the fill |
| ins_mru | output | 1 | 1: insert the filled line at MRU; 0: insert at LRU |
| follow_bip | output | 1 | 1: follower sets currently use bimodal insertion |

## Verification
`ins_mru` is combinational and is due in the same cycle as its fill. The bench therefore drives each cycle's inputs just after a falling edge and samples `ins_mru` one nanosecond later, before the rising edge. A miss affects the counter, and with it `follow_bip`, only at the following rising edge. A fill likewise steps the LFSR only at that edge. The bench model applies both updates after the sample, so each check compares against the state from the end of the previous cycle. Long directed runs push the counter against both saturation limits and then count back across the midpoint. These runs show the saturation through the exact cycle in which `follow_bip` flips. Seeded random traffic then mixes leader and follower misses with fills.

// File: rtl/set_duel_insert.sv
module set_duel_insert #(
  parameter int IDX_W    = 10,
  parameter int FIELD_W  = 5,
  parameter int CNT_W    = 10,
  parameter int RND_W    = 16,
  parameter int THR_LOG2 = 5,
  parameter logic [RND_W-1:0] RND_SEED = 16'hACE1,
  parameter logic [RND_W-1:0] RND_TAPS = 16'hB400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_vld,
  input  logic [IDX_W-1:0] miss_idx,
  input  logic             fill_vld,
  input  logic [IDX_W-1:0] fill_idx,
  output logic             ins_mru,
  output logic             follow_bip
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;
  localparam logic [CNT_W-1:0] CNT_MID = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt;
  logic [RND_W-1:0] rnd;

  // leader detection: upper field compared with lower field
  logic [FIELD_W-1:0] m_hi, m_lo, f_hi, f_lo;
  assign m_hi = miss_idx[2*FIELD_W-1:FIELD_W];
  assign m_lo = miss_idx[FIELD_W-1:0];
  assign f_hi = fill_idx[2*FIELD_W-1:FIELD_W];
  assign f_lo = fill_idx[FIELD_W-1:0];

  logic miss_lead_mru, miss_lead_bip, fill_lead_mru, fill_lead_bip;
  assign miss_lead_mru = miss_vld && (m_hi == m_lo);
  assign miss_lead_bip = miss_vld && (m_hi == ~m_lo);
  assign fill_lead_mru = (f_hi == f_lo);
  assign fill_lead_bip = (f_hi == ~f_lo);

  logic at_max, at_min;
  assign at_max = (cnt == CNT_MAX);
  assign at_min = (cnt == CNT_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= CNT_MID;
    else if (miss_lead_mru && !at_max)
      cnt <= cnt + 1'b1;
    else if (miss_lead_bip && !at_min)
      cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rnd <= RND_SEED;
    else if (fill_vld)
      rnd <= (rnd >> 1) ^ (rnd[0] ? RND_TAPS : '0);
  end

  logic bip_draw;
  assign bip_draw   = (rnd[THR_LOG2-1:0] == '0);
  assign follow_bip = cnt[CNT_W-1];

  always_comb begin
    if (!fill_vld)          ins_mru = 1'b0;
    else if (fill_lead_mru) ins_mru = 1'b1;
    else if (fill_lead_bip) ins_mru = bip_draw;
    else                    ins_mru = follow_bip ? bip_draw : 1'b1;
  end

  p_cnt_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && (m_hi == m_lo) && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
  p_cnt_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && (m_hi == m_lo) && cnt == CNT_MAX) |=> cnt == CNT_MAX);
  p_cnt_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && (m_hi == ~m_lo) && cnt == CNT_MIN) |=> cnt == CNT_MIN);
  p_follower_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_vld || ((m_hi != m_lo) && (m_hi != ~m_lo))) |=> $stable(cnt));
  p_rnd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_vld |=> $stable(rnd));
  p_rnd_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rnd != '0);
  p_no_fill_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_vld |-> !ins_mru);

endmodule

// File: tb/tb_set_duel_insert.sv
module tb_set_duel_insert;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_vld = 1'b0, fill_vld = 1'b0;
  logic [9:0] miss_idx = '0, fill_idx = '0;
  logic ins_mru, follow_bip;

  always #2.5 clk = ~clk;

  set_duel_insert dut (.clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_idx(miss_idx),
                       .fill_vld(fill_vld), .fill_idx(fill_idx), .ins_mru(ins_mru),
                       .follow_bip(follow_bip));

  int checks = 0, fails = 0;
  bit done = 0;
  int m_cnt;
  logic [15:0] m_rnd;

  localparam logic [9:0] LEAD_MRU = 10'b00011_00011;
  localparam logic [9:0] LEAD_BIP = 10'b00011_11100;
  localparam logic [9:0] FOLLOW  = 10'b00000_00001;

  // R2 classification: 0 follower, 1 MRU-leader, 2 bimodal-leader
  function automatic int kind(input logic [9:0] idx);
    if (idx[9:5] == idx[4:0]) return 1;
    if (idx[9:5] == ~idx[4:0]) return 2;
    return 0;
  endfunction

  function automatic bit draw(input logic [15:0] s);
    return s[4:0] == 5'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit mv, input logic [9:0] mi, input bit fv, input logic [9:0] fi);
    int k;
    bit e;
    @(negedge clk);
    miss_vld = mv; miss_idx = mi; fill_vld = fv; fill_idx = fi;
    #1;
    chk(follow_bip === (m_cnt >= 512), "R6 follow_bip", follow_bip, m_cnt >= 512);
    if (fv) begin
      k = kind(fi);
      if (k == 1) begin
        chk(ins_mru === 1'b1, "R7 MRU-leader fill", ins_mru, 1);
      end else if (k == 2) begin
        e = draw(m_rnd);
        chk(ins_mru === e, "R8/R10 bimodal-leader fill", ins_mru, e);
      end else begin
        e = (m_cnt >= 512) ? draw(m_rnd) : 1'b1;
        chk(ins_mru === e, "R9 follower fill", ins_mru, e);
      end
    end else begin
      chk(ins_mru === 1'b0, "R11 idle ins_mru", ins_mru, 0);
    end
    if (mv) begin
      k = kind(mi);
      if (k == 1 && m_cnt < 1023) m_cnt++;
      else if (k == 2 && m_cnt > 0) m_cnt--;
    end
    if (fv) m_rnd = (m_rnd >> 1) ^ (m_rnd[0] ? 16'hB400 : 16'h0000);
  endtask

  function automatic logic [9:0] rand_idx();
    logic [4:0] f;
    int r;
    f = 5'($urandom);
    r = $urandom % 4;
    if (r == 0) return {f, f};
    if (r == 1) return {f, ~f};
    return 10'($urandom);
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    m_cnt = 511;
    m_rnd = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(follow_bip === 1'b0, "R1 reset follow_bip", follow_bip, 0);
    chk(ins_mru === 1'b0, "R1 reset ins_mru", ins_mru, 0);
    // R1: first bimodal-leader fill uses seed ACE1 (low bits 00001 -> LRU)
    step(0, '0, 1, LEAD_BIP);
    // R5: follower misses do not move the counter
    for (int i = 0; i < 50; i++) step(1, FOLLOW, 0, '0);
    step(1, LEAD_MRU, 1, FOLLOW);   // R3: 511 -> 512
    step(0, '0, 1, FOLLOW);         // R9: follower now bimodal
    step(1, LEAD_BIP, 0, '0);       // R4: back to 511
    step(0, '0, 1, FOLLOW);
    // R3 saturation at 1023, then count down across the midpoint
    for (int i = 0; i < 620; i++) step(1, LEAD_MRU, i[0], LEAD_BIP);
    for (int i = 0; i < 513; i++) step(1, LEAD_BIP, i[1], FOLLOW);
    // R4 saturation at 0, then count up across the midpoint
    for (int i = 0; i < 620; i++) step(1, LEAD_BIP, 1, LEAD_MRU);
    for (int i = 0; i < 513; i++) step(1, LEAD_MRU, i[0], FOLLOW);
    // seeded random traffic
    for (int i = 0; i < 4000; i++) step($urandom % 3 != 0, rand_idx(), $urandom % 2, rand_idx());
    step(0, '0, 0, '0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule